// File: doc/BRIEF.md
# Bus Configuration Register with Access-Width Detection

This block holds a 16-bit bus configuration register for a network controller. It sits behind a plain register port made of an address, byte enables, write data, a write strobe and a registered read path. It exports each field as a steady control output. The controller's run state gates every software write. Fields accept new values only while the controller reports that it is halted or paused. At any other time a write leaves the register as it was.

One field is a double-word I/O mode flag that software cannot write. The block watches the bus for a full four-byte write to the data-port offset and sets the flag when it sees one. After that the flag stays set. Only a hard reset clears it, or a load from the configuration EEPROM image that carries a zero for that bit. A hard reset returns every field to its default. A soft reset leaves every field as it is and clears only the read holding register.

Top module: `bus_cfg_reg`

## Requirements
- R1: In the cycle after hard reset is released, ext_req, burst_rd_en, burst_wr_en and dword_io are 0, spare_bits is 3'b001 and rdata is 0.
- R2: While halted or paused is high, a write to REG_OFFS with be[0] set loads bit 6 into burst_rd_en, bit 5 into burst_wr_en and bits 2:0 into spare_bits. A write with be[1] set loads bit 8 into ext_req. A field whose byte lane is not enabled keeps its value.
- R3: While both halted and paused are low, a write to REG_OFFS leaves every field unchanged.
- R4: A write to REG_OFFS never changes dword_io, whatever bit 7 of the data holds.
- R5: A write to DPORT_OFFS with all four byte enables high sets dword_io in the next cycle, in any run state. A write to DPORT_OFFS with fewer byte enables leaves dword_io unchanged.
- R6: Once set, dword_io stays 1 until a hard reset or an EEPROM load whose image bit is 0.
- R7: When ee_load is high for one cycle, dword_io takes the value of ee_dwio in the next cycle. This holds even when a full-width data-port write arrives in the same cycle.
- R8: In the register image, bits 15:9 and bits 4:3 always read 0. The image places ext_req at bit 8, dword_io at bit 7, burst_rd_en at bit 6, burst_wr_en at bit 5 and spare_bits at bits 2:0.
- R9: A soft reset changes no field, and rdata reads 0 in the cycle after it.
- R10: A rise or fall of halted or paused with no write changes no field.
- R11: rdata shows the register image one cycle after addr equals REG_OFFS, and shows 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| hrst | input | 1 | Hard reset, synchronous, active high |
| srst | input | 1 | Soft reset, synchronous, active high |
| halted | input | 1 | Controller stopped status |
| paused | input | 1 | Controller suspended status |
| wr | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte offset of the access |
| be | input | BE_W | Byte enables of the access |
| wdata | input | 16 | Write data, low half of the bus |
| ee_load | input | 1 | One-cycle EEPROM image load strobe |
| ee_dwio | input | 1 | EEPROM image bit for the double-word mode |
| rdata | output | 16 | Registered read data |
| ext_req | output | 1 | External request control |
| burst_rd_en | output | 1 | Burst enable for memory reads |
| burst_wr_en | output | 1 | Burst enable for memory writes |
| dword_io | output | 1 | Double-word I/O mode flag |
| spare_bits | output | 3 | Spare field with no function |

## Verification
The bench builds the block with ADDR_W=8, BE_W=4, REG_OFFS=8'h24, DPORT_OFFS=8'h10 and SPARE_RST=3'b001. These values let the bench tell a full-width data-port write from a two-lane write. They let it aim an access at an offset that matches neither decode. They also give a spare-field default that no write pattern in the bench can reproduce by chance. The bench changes the run state between writes, issues a soft reset between reads, and lines up an EEPROM load with a full-width write in the same cycle to check which one wins.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned POS_EXT   = 8;
  localparam int unsigned POS_DW    = 7;
  localparam int unsigned POS_BRD   = 6;
  localparam int unsigned POS_BWR   = 5;
  localparam int unsigned POS_SPARE = 0;
  localparam int unsigned SPARE_W   = 3;

  typedef struct packed {
    logic               ext_req;
    logic               dword_io;
    logic               burst_rd;
    logic               burst_wr;
    logic [SPARE_W-1:0] spare;
  } cfg_t;

  function automatic logic [REG_W-1:0] pack_image(input cfg_t c);
    logic [REG_W-1:0] img;
    img = '0;
    img[POS_EXT] = c.ext_req;
    img[POS_DW]  = c.dword_io;
    img[POS_BRD] = c.burst_rd;
    img[POS_BWR] = c.burst_wr;
    img[POS_SPARE +: SPARE_W] = c.spare;
    return img;
  endfunction
endpackage

// File: rtl/bcfg_decode.sv
module bcfg_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BE_W = 4,
  parameter logic [ADDR_W-1:0] REG_OFFS = 8'h24,
  parameter logic [ADDR_W-1:0] DPORT_OFFS = 8'h10
) (
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BE_W-1:0]      be,
  input  logic                 halted,
  input  logic                 paused,
  output logic [bcfg_pkg::REG_W/8-1:0] lane_wr,
  output logic                 wide_dport_wr,
  output logic                 reg_sel
);
  localparam int unsigned LANES = bcfg_pkg::REG_W / 8;

  logic reg_hit;
  logic wr_open;

  assign reg_sel = (addr == REG_OFFS);
  assign reg_hit = wr & reg_sel;
  assign wr_open = halted | paused;
  assign wide_dport_wr = wr & (addr == DPORT_OFFS) & (&be);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_wr[i] = reg_hit & wr_open & be[i];
  end
endmodule

// File: rtl/bcfg_dwio.sv
module bcfg_dwio (
  input  logic clk,
  input  logic hrst,
  input  logic ee_load,
  input  logic ee_dwio,
  input  logic wide_dport_wr,
  output logic dword_io
);
  always_ff @(posedge clk) begin
    if (hrst)               dword_io <= 1'b0;
    else if (ee_load)       dword_io <= ee_dwio;
    else if (wide_dport_wr) dword_io <= 1'b1;
  end
endmodule

// File: rtl/bcfg_fields.sv
module bcfg_fields #(
  parameter logic [bcfg_pkg::SPARE_W-1:0] SPARE_RST = 3'b001
) (
  input  logic       clk,
  input  logic       hrst,
  input  logic [1:0] lane_wr,
  input  logic       d_ext,
  input  logic       d_brd,
  input  logic       d_bwr,
  input  logic [bcfg_pkg::SPARE_W-1:0] d_spare,
  output logic       ext_req,
  output logic       burst_rd,
  output logic       burst_wr,
  output logic [bcfg_pkg::SPARE_W-1:0] spare
);
  always_ff @(posedge clk) begin
    if (hrst) begin
      burst_rd <= 1'b0;
      burst_wr <= 1'b0;
      spare    <= SPARE_RST;
    end else if (lane_wr[0]) begin
      burst_rd <= d_brd;
      burst_wr <= d_bwr;
      spare    <= d_spare;
    end
  end

  always_ff @(posedge clk) begin
    if (hrst)            ext_req <= 1'b0;
    else if (lane_wr[1]) ext_req <= d_ext;
  end
endmodule

// File: rtl/bcfg_rdport.sv
module bcfg_rdport (
  input  logic clk,
  input  logic hrst,
  input  logic srst,
  input  logic sel,
  input  logic [bcfg_pkg::REG_W-1:0] image,
  output logic [bcfg_pkg::REG_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (hrst || srst) rdata <= '0;
    else if (sel)     rdata <= image;
    else              rdata <= '0;
  end
endmodule

// File: rtl/bus_cfg_reg.sv
module bus_cfg_reg #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BE_W = 4,
  parameter logic [ADDR_W-1:0] REG_OFFS = 8'h24,
  parameter logic [ADDR_W-1:0] DPORT_OFFS = 8'h10,
  parameter logic [2:0] SPARE_RST = 3'b001
) (
  input  logic              clk,
  input  logic              hrst,
  input  logic              srst,
  input  logic              halted,
  input  logic              paused,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  input  logic [15:0]       wdata,
  input  logic              ee_load,
  input  logic              ee_dwio,
  output logic [15:0]       rdata,
  output logic              ext_req,
  output logic              burst_rd_en,
  output logic              burst_wr_en,
  output logic              dword_io,
  output logic [2:0]        spare_bits
);
  import bcfg_pkg::*;

  logic [REG_W/8-1:0] lane_wr;
  logic               wide_dport_wr;
  logic               reg_sel;
  cfg_t               cur;
  logic               unused_wbits;

  assign unused_wbits = ^{wdata[15:9], wdata[7], wdata[4:3]};

  bcfg_decode #(
    .ADDR_W(ADDR_W), .BE_W(BE_W), .REG_OFFS(REG_OFFS), .DPORT_OFFS(DPORT_OFFS)
  ) u_decode (
    .wr(wr), .addr(addr), .be(be), .halted(halted), .paused(paused),
    .lane_wr(lane_wr), .wide_dport_wr(wide_dport_wr), .reg_sel(reg_sel)
  );

  bcfg_fields #(.SPARE_RST(SPARE_RST)) u_fields (
    .clk(clk), .hrst(hrst), .lane_wr(lane_wr),
    .d_ext(wdata[POS_EXT]), .d_brd(wdata[POS_BRD]), .d_bwr(wdata[POS_BWR]),
    .d_spare(wdata[POS_SPARE +: SPARE_W]),
    .ext_req(ext_req), .burst_rd(burst_rd_en), .burst_wr(burst_wr_en),
    .spare(spare_bits)
  );

  bcfg_dwio u_dwio (
    .clk(clk), .hrst(hrst), .ee_load(ee_load), .ee_dwio(ee_dwio),
    .wide_dport_wr(wide_dport_wr), .dword_io(dword_io)
  );

  assign cur.ext_req  = ext_req;
  assign cur.dword_io = dword_io;
  assign cur.burst_rd = burst_rd_en;
  assign cur.burst_wr = burst_wr_en;
  assign cur.spare    = spare_bits;

  bcfg_rdport u_rdport (
    .clk(clk), .hrst(hrst), .srst(srst), .sel(reg_sel),
    .image(pack_image(cur)), .rdata(rdata)
  );
endmodule

// File: rtl/bus_cfg_reg_chk.sv
module bus_cfg_reg_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BE_W = 4,
  parameter logic [ADDR_W-1:0] REG_OFFS = 8'h24,
  parameter logic [ADDR_W-1:0] DPORT_OFFS = 8'h10,
  parameter logic [2:0] SPARE_RST = 3'b001
) (
  input logic              clk,
  input logic              hrst,
  input logic              srst,
  input logic              halted,
  input logic              paused,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [BE_W-1:0]   be,
  input logic [15:0]       wdata,
  input logic              ee_load,
  input logic              ee_dwio,
  input logic [15:0]       rdata,
  input logic              ext_req,
  input logic              burst_rd_en,
  input logic              burst_wr_en,
  input logic              dword_io,
  input logic [2:0]        spare_bits
);
  logic [5:0] flds;
  assign flds = {ext_req, burst_rd_en, burst_wr_en, spare_bits};

  a_r1_reset_values: assert property (@(posedge clk) disable iff (hrst)
    $fell(hrst) |-> (flds == {3'b000, SPARE_RST}) && !dword_io);

  a_r3_running_write_ignored: assert property (@(posedge clk) disable iff (hrst)
    (wr && addr == REG_OFFS && !halted && !paused) |=> $stable(flds));

  a_r5_wide_write_sets: assert property (@(posedge clk) disable iff (hrst)
    (wr && addr == DPORT_OFFS && (&be) && !ee_load) |=> dword_io);

  a_r6_dw_sticky: assert property (@(posedge clk) disable iff (hrst)
    (dword_io && !ee_load) |=> dword_io);

  a_r7_ee_load: assert property (@(posedge clk) disable iff (hrst)
    ee_load |=> (dword_io == $past(ee_dwio)));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (hrst)
    (rdata[15:9] == 7'd0) && (rdata[4:3] == 2'd0));

  a_r9_soft_reset_keeps: assert property (@(posedge clk) disable iff (hrst)
    (srst && !wr && !ee_load) |=> ($stable(flds) && $stable(dword_io)));

  a_r10_runstate_change_keeps: assert property (@(posedge clk) disable iff (hrst)
    (!wr && !ee_load) |=> $stable(flds));
endmodule

bind bus_cfg_reg bus_cfg_reg_chk #(
  .ADDR_W(ADDR_W), .BE_W(BE_W), .REG_OFFS(REG_OFFS),
  .DPORT_OFFS(DPORT_OFFS), .SPARE_RST(SPARE_RST)
) u_chk (.*);

// File: tb/tb_bus_cfg_reg.sv
module tb_bus_cfg_reg;
  localparam logic [7:0] REG_A = 8'h24;
  localparam logic [7:0] DP_A  = 8'h10;

  logic clk = 1'b0;
  logic hrst = 1'b1, srst = 1'b0, halted = 1'b0, paused = 1'b0, wr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [3:0] be = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic ee_load = 1'b0, ee_dwio = 1'b0;
  logic [15:0] rdata;
  logic ext_req, burst_rd_en, burst_wr_en, dword_io;
  logic [2:0] spare_bits;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  bus_cfg_reg #(.ADDR_W(8), .BE_W(4), .REG_OFFS(REG_A), .DPORT_OFFS(DP_A),
                .SPARE_RST(3'b001)) dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] outs_image();
    return {7'd0, ext_req, dword_io, burst_rd_en, burst_wr_en, 2'b00, spare_bits};
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [3:0] b, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    wr = 1'b0; be = 4'h0;
  endtask

  task automatic read_at(input logic [7:0] a, output logic [15:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    hrst = 1'b1;
    repeat (2) @(negedge clk);
    hrst = 1'b0;
    check("R1 outputs", outs_image(), 16'h0001);
    check("R1 rdata", rdata, 16'h0000);
    read_at(REG_A, v);
    check("R11 R8 reset image", v, 16'h0001);
  endtask

  task automatic t_write_open();
    logic [15:0] v;
    halted = 1'b1;
    bus_write(REG_A, 4'b0011, 16'hFFFF);
    check("R2 R4 halted full write", outs_image(), 16'h0167);
    read_at(REG_A, v);
    check("R8 image reserved zero", v, 16'h0167);
    bus_write(REG_A, 4'b0001, 16'h0000);
    check("R2 low lane only", outs_image(), 16'h0100);
    halted = 1'b0; paused = 1'b1;
    bus_write(REG_A, 4'b0011, 16'h0062);
    check("R2 paused write", outs_image(), 16'h0062);
  endtask

  task automatic t_write_running();
    halted = 1'b0; paused = 1'b0;
    bus_write(REG_A, 4'b0011, 16'hFF9D);
    check("R3 running write ignored", outs_image(), 16'h0062);
    halted = 1'b1;
    bus_write(8'h30, 4'b0011, 16'hFFFF);
    check("R11 other offset no write", outs_image(), 16'h0062);
    halted = 1'b0;
  endtask

  task automatic t_runstate();
    @(negedge clk); halted = 1'b1;
    @(negedge clk); halted = 1'b0; paused = 1'b1;
    @(negedge clk); paused = 1'b0;
    @(negedge clk);
    check("R10 run state edges", outs_image(), 16'h0062);
  endtask

  task automatic t_dword();
    logic [15:0] v;
    bus_write(DP_A, 4'b0011, 16'h1234);
    check("R5 narrow write", {15'd0, dword_io}, 16'h0000);
    bus_write(DP_A, 4'b0111, 16'h1234);
    check("R5 three lanes", {15'd0, dword_io}, 16'h0000);
    bus_write(DP_A, 4'b1111, 16'h0000);
    check("R5 wide write sets", {15'd0, dword_io}, 16'h0001);
    read_at(REG_A, v);
    check("R11 R8 image with mode", v, 16'h00E2);
  endtask

  task automatic t_sticky();
    halted = 1'b1;
    bus_write(REG_A, 4'b0011, 16'h0000);
    check("R4 R6 reg write keeps mode", {15'd0, dword_io}, 16'h0001);
    check("R2 fields cleared", outs_image(), 16'h0080);
    halted = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 mode holds", {15'd0, dword_io}, 16'h0001);
  endtask

  task automatic t_soft();
    logic [15:0] v;
    halted = 1'b1;
    bus_write(REG_A, 4'b0011, 16'h0165);
    halted = 1'b0;
    read_at(REG_A, v);
    check("R11 before soft reset", v, 16'h01E5);
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    check("R9 rdata cleared", rdata, 16'h0000);
    check("R9 fields kept", outs_image(), 16'h01E5);
    read_at(REG_A, v);
    check("R9 image after soft reset", v, 16'h01E5);
  endtask

  task automatic t_eeprom();
    @(negedge clk);
    ee_load = 1'b1; ee_dwio = 1'b0;
    @(negedge clk);
    ee_load = 1'b0;
    check("R6 R7 load zero clears", {15'd0, dword_io}, 16'h0000);
    @(negedge clk);
    ee_load = 1'b1; ee_dwio = 1'b0;
    wr = 1'b1; addr = DP_A; be = 4'b1111;
    @(negedge clk);
    ee_load = 1'b0; wr = 1'b0; be = 4'h0;
    check("R7 load beats wide write", {15'd0, dword_io}, 16'h0000);
    @(negedge clk);
    ee_load = 1'b1; ee_dwio = 1'b1;
    @(negedge clk);
    ee_load = 1'b0; ee_dwio = 1'b0;
    check("R7 load one sets", {15'd0, dword_io}, 16'h0001);
    check("R7 other fields kept", outs_image(), 16'h01E5);
  endtask

  task automatic t_read_other();
    logic [15:0] v;
    read_at(8'h30, v);
    check("R11 other offset reads zero", v, 16'h0000);
    read_at(DP_A, v);
    check("R11 data port reads zero", v, 16'h0000);
  endtask

  task automatic t_hard_again();
    @(negedge clk);
    hrst = 1'b1;
    @(negedge clk);
    hrst = 1'b0;
    check("R1 R6 hard reset clears all", outs_image(), 16'h0001);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_write_open();
    t_write_running();
    t_runstate();
    t_dword();
    t_sticky();
    t_soft();
    t_eeprom();
    t_read_other();
    t_hard_again();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule